// File: doc/BRIEF.md
# Doorbell Queue Slot Table

This block keeps a small content-addressed table. Each entry binds a run-list queue to the doorbell offset that software rings for it. A control agent sends requests on a valid/ready channel. An attach request stores a doorbell offset, a ring base address, a ring size code and a read-pointer writeback address in the lowest-indexed free slot. A detach request releases the slot that holds a given doorbell. A kick request looks up the slot that holds a doorbell and issues a one-cycle start pulse. The pulse carries that slot's index and the new write-pointer offset, and the downstream queue engine selected by the index uses it.

Every accepted request is answered one cycle later by a done pulse with two error flags. One flag reports that no slot was free. The other reports that no slot holds the doorbell. A failed request changes nothing. A flush input releases every slot at once, and the request channel is held not-ready while the flush is raised. The stored fields of every slot are driven out continuously so that the queue engines can read their configuration.

Top module: `qslot_table`

## Requirements
- R1: After reset every slot is free and `rsp_done`, both error flags and `start_valid` are low.
- R2: An attach request (`req_op` = 0) with at least one free slot occupies the free slot with the lowest index. The following cycle `slot_busy` shows the slot as held, the slot's fields on the `slot_*` outputs equal the request's doorbell, base, size and writeback address, and `rsp_slot` gives the slot index.
- R3: An attach request while every slot is held raises `rsp_err_nofree` with the done pulse and leaves `slot_busy` and all stored fields unchanged.
- R4: A detach request (`req_op` = 1) releases the lowest-indexed held slot whose doorbell equals `req_doorbell` and reports that index on `rsp_slot`. Free slots never match.
- R5: A detach request whose doorbell is held by no slot raises `rsp_err_nomatch` and changes no slot.
- R6: A kick request (`req_op` = 2) that matches a held slot raises `start_valid` for exactly one cycle, in the cycle after acceptance. `start_slot` is the lowest matching index and `start_wptr` is the request's write-pointer offset. Slot state does not change.
- R7: A kick request that matches no held slot raises `rsp_err_nomatch` and does not raise `start_valid`.
- R8: Each accepted request (`req_valid` and `req_ready` high at a clock edge) produces exactly one `rsp_done` pulse in the following cycle, and `rsp_done` is low in every other cycle. The error flags are high only together with `rsp_done`, and never both at once.
- R9: While `flush_all` is high, `req_ready` is low and no request is accepted. In the cycle after `flush_all` is sampled high, every slot is free.
- R10: Request code 3 is reserved. It is accepted and answered with a done pulse, with no error flag, no start pulse and no change to any slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_all | input | 1 | Release every slot |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 2 | 0 attach, 1 detach, 2 kick, 3 reserved |
| req_doorbell | input | DB_W | Doorbell offset key |
| req_ring_base | input | ADDR_W | Ring base address (attach) |
| req_ring_size | input | SIZE_W | Ring size code (attach) |
| req_wb_addr | input | ADDR_W | Read-pointer writeback address (attach) |
| req_wptr | input | PTR_W | New write-pointer offset (kick) |
| rsp_done | output | 1 | Response pulse |
| rsp_err_nofree | output | 1 | Attach found no free slot |
| rsp_err_nomatch | output | 1 | Detach or kick found no matching slot |
| rsp_slot | output | IDX_W | Slot taken, released or matched |
| start_valid | output | 1 | Start pulse to a queue engine |
| start_slot | output | IDX_W | Queue engine to start |
| start_wptr | output | PTR_W | Write-pointer offset for the started queue |
| slot_busy | output | NUM_SLOTS | Held flag per slot |
| slot_doorbell | output | NUM_SLOTS*DB_W | Stored doorbells, slot 0 in the low bits |
| slot_ring_base | output | NUM_SLOTS*ADDR_W | Stored ring bases |
| slot_ring_size | output | NUM_SLOTS*SIZE_W | Stored ring size codes |
| slot_wb_addr | output | NUM_SLOTS*ADDR_W | Stored writeback addresses |

## Verification
The assertions assume that the request fields are stable and known whenever `req_valid` is high, and that `flush_all` and `rst_n` are never unknown once reset is released. They do not assume that doorbells are unique. The bench therefore attaches the same doorbell to two slots on purpose, so that lowest-index matching is exercised. All inputs are driven shortly after a rising edge, so they are settled at the next edge. A random phase uses a pool of four doorbells, which keeps hits, misses, a full table and duplicate keys all frequent. It also raises `flush_all` at random, sometimes while a request is waiting.

// File: rtl/qslot_pkg.sv
package qslot_pkg;

   typedef enum logic [1:0] {
      OP_ATTACH = 2'd0,
      OP_DETACH = 2'd1,
      OP_KICK   = 2'd2,
      OP_RSVD   = 2'd3
   } qslot_op_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/qslot_pick.sv
module qslot_pick #(
   parameter int N    = 2,
   parameter int IW   = 1
) (
   input  logic [N-1:0]  vec_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);

   if (N < 1) begin : g_bad_n
      $error("qslot_pick: N must be at least 1");
   end
   if (IW < 1 || (N > 1 && (1 << IW) < N)) begin : g_bad_iw
      $error("qslot_pick: IW too narrow for N");
   end

   assign found_o = |vec_i;

   if (N == 2) begin : g_pair
      assign idx_o = vec_i[0] ? IW'(0) : IW'(1);
   end else begin : g_scan
      always_comb begin
         idx_o = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
         end
      end
   end

endmodule

// File: rtl/qslot_entry.sv
module qslot_entry #(
   parameter int DB_W   = 16,
   parameter int ADDR_W = 48,
   parameter int SIZE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_i,
   input  logic              clr_i,
   input  logic              flush_i,
   input  logic [DB_W-1:0]   db_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [SIZE_W-1:0] size_i,
   input  logic [ADDR_W-1:0] wb_i,
   input  logic [DB_W-1:0]   probe_db_i,
   output logic              busy_o,
   output logic [DB_W-1:0]   db_o,
   output logic [ADDR_W-1:0] base_o,
   output logic [SIZE_W-1:0] size_o,
   output logic [ADDR_W-1:0] wb_o,
   output logic              hit_o
);

   logic              busy_q;
   logic [DB_W-1:0]   db_q;
   logic [ADDR_W-1:0] base_q;
   logic [SIZE_W-1:0] size_q;
   logic [ADDR_W-1:0] wb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
      end else if (flush_i) begin
         busy_q <= 1'b0;
      end else if (set_i) begin
         busy_q <= 1'b1;
      end else if (clr_i) begin
         busy_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         db_q   <= '0;
         base_q <= '0;
         size_q <= '0;
         wb_q   <= '0;
      end else if (set_i && !flush_i) begin
         db_q   <= db_i;
         base_q <= base_i;
         size_q <= size_i;
         wb_q   <= wb_i;
      end
   end

   assign busy_o = busy_q;
   assign db_o   = db_q;
   assign base_o = base_q;
   assign size_o = size_q;
   assign wb_o   = wb_q;
   assign hit_o  = busy_q && (db_q == probe_db_i);

   // R2: only a free slot is ever filled
   a_r2_fill_only_free: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |-> !busy_q);

   // R2: a fill captures the request fields
   a_r2_fill_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !flush_i) |=> (busy_q && db_q == $past(db_i) && base_q == $past(base_i)));

   // R4: only a held slot is released
   a_r4_clear_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |-> busy_q);

   // R9: flush leaves the slot free
   a_r9_flush_frees: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !busy_q);

endmodule

// File: rtl/qslot_table.sv
module qslot_table
   import qslot_pkg::*;
#(
   parameter int NUM_SLOTS = 2,
   parameter int DB_W      = 16,
   parameter int ADDR_W    = 48,
   parameter int SIZE_W    = 6,
   parameter int PTR_W     = 32,
   localparam int IDX_W    = idx_width(NUM_SLOTS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush_all,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic [1:0]                  req_op,
   input  logic [DB_W-1:0]             req_doorbell,
   input  logic [ADDR_W-1:0]           req_ring_base,
   input  logic [SIZE_W-1:0]           req_ring_size,
   input  logic [ADDR_W-1:0]           req_wb_addr,
   input  logic [PTR_W-1:0]            req_wptr,
   output logic                        rsp_done,
   output logic                        rsp_err_nofree,
   output logic                        rsp_err_nomatch,
   output logic [IDX_W-1:0]            rsp_slot,
   output logic                        start_valid,
   output logic [IDX_W-1:0]            start_slot,
   output logic [PTR_W-1:0]            start_wptr,
   output logic [NUM_SLOTS-1:0]        slot_busy,
   output logic [NUM_SLOTS*DB_W-1:0]   slot_doorbell,
   output logic [NUM_SLOTS*ADDR_W-1:0] slot_ring_base,
   output logic [NUM_SLOTS*SIZE_W-1:0] slot_ring_size,
   output logic [NUM_SLOTS*ADDR_W-1:0] slot_wb_addr
);

   if (NUM_SLOTS < 1) begin : g_bad_slots
      $error("qslot_table: NUM_SLOTS must be at least 1");
   end
   if (DB_W < 1 || ADDR_W < 1 || SIZE_W < 1 || PTR_W < 1) begin : g_bad_width
      $error("qslot_table: field widths must be positive");
   end

   logic                 accept;
   logic                 op_attach, op_detach, op_kick;
   logic [NUM_SLOTS-1:0] busy_vec, free_vec, hit_vec, set_vec, clr_vec;
   logic                 free_found, hit_found;
   logic [IDX_W-1:0]     free_idx, hit_idx;

   assign req_ready = !flush_all;
   assign accept    = req_valid && req_ready;
   assign op_attach = (req_op == OP_ATTACH);
   assign op_detach = (req_op == OP_DETACH);
   assign op_kick   = (req_op == OP_KICK);

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign set_vec[s] = accept && op_attach && free_found && (free_idx == IDX_W'(s));
      assign clr_vec[s] = accept && op_detach && hit_found  && (hit_idx  == IDX_W'(s));

      qslot_entry #(
         .DB_W   (DB_W),
         .ADDR_W (ADDR_W),
         .SIZE_W (SIZE_W)
      ) i_entry (
         .clk        (clk),
         .rst_n      (rst_n),
         .set_i      (set_vec[s]),
         .clr_i      (clr_vec[s]),
         .flush_i    (flush_all),
         .db_i       (req_doorbell),
         .base_i     (req_ring_base),
         .size_i     (req_ring_size),
         .wb_i       (req_wb_addr),
         .probe_db_i (req_doorbell),
         .busy_o     (busy_vec[s]),
         .db_o       (slot_doorbell [s*DB_W   +: DB_W]),
         .base_o     (slot_ring_base[s*ADDR_W +: ADDR_W]),
         .size_o     (slot_ring_size[s*SIZE_W +: SIZE_W]),
         .wb_o       (slot_wb_addr  [s*ADDR_W +: ADDR_W]),
         .hit_o      (hit_vec[s])
      );
   end

   assign free_vec  = ~busy_vec;
   assign slot_busy = busy_vec;

   qslot_pick #(.N(NUM_SLOTS), .IW(IDX_W)) i_pick_free (
      .vec_i   (free_vec),
      .found_o (free_found),
      .idx_o   (free_idx)
   );

   qslot_pick #(.N(NUM_SLOTS), .IW(IDX_W)) i_pick_hit (
      .vec_i   (hit_vec),
      .found_o (hit_found),
      .idx_o   (hit_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_done        <= 1'b0;
         rsp_err_nofree  <= 1'b0;
         rsp_err_nomatch <= 1'b0;
         rsp_slot        <= '0;
         start_valid     <= 1'b0;
         start_slot      <= '0;
         start_wptr      <= '0;
      end else begin
         rsp_done        <= accept;
         rsp_err_nofree  <= accept && op_attach && !free_found;
         rsp_err_nomatch <= accept && (op_detach || op_kick) && !hit_found;
         start_valid     <= accept && op_kick && hit_found;
         if (accept) begin
            if (op_attach && free_found) begin
               rsp_slot <= free_idx;
            end else if ((op_detach || op_kick) && hit_found) begin
               rsp_slot <= hit_idx;
            end else begin
               rsp_slot <= '0;
            end
         end
         if (accept && op_kick && hit_found) begin
            start_slot <= hit_idx;
            start_wptr <= req_wptr;
         end
      end
   end

   // R8: one done pulse per accepted request
   a_r8_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> rsp_done);
   a_r8_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> !rsp_done);
   a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_err_nofree || rsp_err_nomatch) |-> rsp_done);
   a_r8_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_err_nofree, rsp_err_nomatch}));

   // R3: a full table rejects an attach and keeps its state
   a_r3_full_rejects: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op_attach && (&busy_vec)) |=> (rsp_err_nofree && $stable(slot_busy)
         && $stable(slot_doorbell)));

   // R5: a detach miss keeps every slot
   a_r5_miss_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op_detach && !(|hit_vec)) |=> (rsp_err_nomatch && $stable(slot_busy)));

   // R6: a start pulse only for a clean kick of a held slot, one cycle long
   a_r6_start_clean: assert property (@(posedge clk) disable iff (!rst_n)
      start_valid |-> (rsp_done && !rsp_err_nomatch && slot_busy[start_slot]));
   a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      (start_valid && !accept) |=> !start_valid);

   // R7: a kick miss starts nothing
   a_r7_miss_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && op_kick && !(|hit_vec)) |=> (rsp_err_nomatch && !start_valid));

   // R9: all slots free after a flush
   a_r9_flush_all_free: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> (slot_busy == '0));

   // R10: the reserved code has no effect beyond the done pulse
   a_r10_reserved_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_op == OP_RSVD) |=> (rsp_done && !rsp_err_nofree && !rsp_err_nomatch
         && !start_valid && $stable(slot_busy)));

endmodule

// File: tb/test_qslot_table.sv
module test_qslot_table;

   localparam int NS = 2;
   localparam int DW = 16;
   localparam int AW = 48;
   localparam int SW = 6;
   localparam int PW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush_all = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_op = 2'd0;
   logic [DW-1:0] req_doorbell = '0;
   logic [AW-1:0] req_ring_base = '0;
   logic [SW-1:0] req_ring_size = '0;
   logic [AW-1:0] req_wb_addr = '0;
   logic [PW-1:0] req_wptr = '0;
   logic          rsp_done, rsp_err_nofree, rsp_err_nomatch;
   logic [0:0]    rsp_slot, start_slot;
   logic          start_valid;
   logic [PW-1:0] start_wptr;
   logic [NS-1:0]    slot_busy;
   logic [NS*DW-1:0] slot_doorbell;
   logic [NS*AW-1:0] slot_ring_base;
   logic [NS*SW-1:0] slot_ring_size;
   logic [NS*AW-1:0] slot_wb_addr;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   qslot_table #(.NUM_SLOTS(NS), .DB_W(DW), .ADDR_W(AW), .SIZE_W(SW), .PTR_W(PW)) i_qslot_table (
      .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_doorbell(req_doorbell), .req_ring_base(req_ring_base),
      .req_ring_size(req_ring_size), .req_wb_addr(req_wb_addr), .req_wptr(req_wptr),
      .rsp_done(rsp_done), .rsp_err_nofree(rsp_err_nofree), .rsp_err_nomatch(rsp_err_nomatch),
      .rsp_slot(rsp_slot), .start_valid(start_valid), .start_slot(start_slot),
      .start_wptr(start_wptr), .slot_busy(slot_busy), .slot_doorbell(slot_doorbell),
      .slot_ring_base(slot_ring_base), .slot_ring_size(slot_ring_size),
      .slot_wb_addr(slot_wb_addr)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit          m_busy [NS];
   logic [DW-1:0] m_db [NS];
   logic [AW-1:0] m_base [NS];
   logic [SW-1:0] m_size [NS];
   logic [AW-1:0] m_wb [NS];
   bit          e_done, e_nf, e_nm, e_start;
   int          e_slot, e_sslot;
   logic [PW-1:0] e_wptr;

   function automatic int find_free();
      for (int i = 0; i < NS; i++) if (!m_busy[i]) return i;
      return -1;
   endfunction

   function automatic int find_db(input logic [DW-1:0] db);
      for (int i = 0; i < NS; i++) if (m_busy[i] && m_db[i] == db) return i;
      return -1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) m_busy[i] = 0;
         e_done = 0; e_nf = 0; e_nm = 0; e_start = 0;
      end else begin
         int k;
         e_done = 0; e_nf = 0; e_nm = 0; e_start = 0;
         if (flush_all) begin
            for (int i = 0; i < NS; i++) m_busy[i] = 0;
         end else if (req_valid) begin
            e_done = 1;
            case (req_op)
               2'd0: begin
                  k = find_free();
                  if (k < 0) e_nf = 1;
                  else begin
                     m_busy[k] = 1; m_db[k] = req_doorbell; m_base[k] = req_ring_base;
                     m_size[k] = req_ring_size; m_wb[k] = req_wb_addr; e_slot = k;
                  end
               end
               2'd1: begin
                  k = find_db(req_doorbell);
                  if (k < 0) e_nm = 1;
                  else begin m_busy[k] = 0; e_slot = k; end
               end
               2'd2: begin
                  k = find_db(req_doorbell);
                  if (k < 0) e_nm = 1;
                  else begin e_start = 1; e_sslot = k; e_wptr = req_wptr; e_slot = k; end
               end
               default: ;
            endcase
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R9 ready", req_ready, !flush_all);
         chk("R8 done", rsp_done, e_done);
         chk("R3 nofree", rsp_err_nofree, e_nf);
         chk("R5/R7 nomatch", rsp_err_nomatch, e_nm);
         chk("R6 start", start_valid, e_start);
         if (e_start) begin
            chk("R6 start_slot", start_slot, e_sslot);
            chk("R6 start_wptr", start_wptr, e_wptr);
         end
         if (e_done && !e_nf && !e_nm && req_op_q != 2'd3)
            chk("R2 rsp_slot", rsp_slot, e_slot);
         for (int i = 0; i < NS; i++) begin
            chk("R4 busy", slot_busy[i], m_busy[i]);
            if (m_busy[i]) begin
               chk("R2 doorbell", slot_doorbell[i*DW +: DW], m_db[i]);
               chk("R2 base", slot_ring_base[i*AW +: AW], m_base[i]);
               chk("R2 size", slot_ring_size[i*SW +: SW], m_size[i]);
               chk("R2 wb", slot_wb_addr[i*AW +: AW], m_wb[i]);
            end
         end
      end
   end

   // op of the request answered in this cycle
   logic [1:0] req_op_q = 2'd0;
   always @(posedge clk) req_op_q <= req_op;

   task automatic issue(input logic [1:0] op, input logic [DW-1:0] db, input logic [PW-1:0] wp);
      @(posedge clk); #2;
      req_valid = 1; req_op = op; req_doorbell = db;
      req_ring_base = {db, 32'h0000_1000}; req_ring_size = SW'(db + 6);
      req_wb_addr = {16'h00f0, db, 16'h0040}; req_wptr = wp;
      @(posedge clk); #2;
      req_valid = 0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk("R1 busy", slot_busy, 2'b00);
      chk("R1 done", rsp_done, 0);
      chk("R1 start", start_valid, 0);
      chk("R1 errs", {rsp_err_nofree, rsp_err_nomatch}, 2'b00);

      issue(2'd0, 16'h00a1, 0);
      chk("R2 first slot", rsp_slot, 0);
      issue(2'd0, 16'h00b2, 0);
      chk("R2 second slot", rsp_slot, 1);
      issue(2'd0, 16'h00c3, 0);
      chk("R3 full", rsp_err_nofree, 1);
      chk("R3 keep", slot_doorbell, {16'h00b2, 16'h00a1});
      issue(2'd2, 16'h00b2, 32'h55);
      chk("R6 pulse", start_valid, 1);
      chk("R6 slot", start_slot, 1);
      chk("R6 wptr", start_wptr, 32'h55);
      @(posedge clk); #2;
      chk("R6 one cycle", start_valid, 0);
      issue(2'd2, 16'h0777, 32'h9);
      chk("R7 miss", rsp_err_nomatch, 1);
      chk("R7 no start", start_valid, 0);
      issue(2'd1, 16'h00a1, 0);
      chk("R4 freed", slot_busy, 2'b10);
      issue(2'd2, 16'h00a1, 32'h3);
      chk("R4 free slot no match", rsp_err_nomatch, 1);
      issue(2'd1, 16'h0999, 0);
      chk("R5 miss", rsp_err_nomatch, 1);
      chk("R5 keep", slot_busy, 2'b10);
      issue(2'd0, 16'h00c3, 0);
      chk("R2 lowest free", rsp_slot, 0);
      issue(2'd3, 16'h00c3, 32'h1);
      chk("R10 done", rsp_done, 1);
      chk("R10 no error", {rsp_err_nofree, rsp_err_nomatch, start_valid}, 3'b000);
      chk("R10 keep", slot_busy, 2'b11);
      // duplicate key in both slots
      issue(2'd1, 16'h00b2, 0);
      issue(2'd0, 16'h00c3, 0);
      issue(2'd2, 16'h00c3, 32'h77);
      chk("R6 lowest match", start_slot, 0);
      issue(2'd1, 16'h00c3, 0);
      chk("R4 lowest match", rsp_slot, 0);
      issue(2'd2, 16'h00c3, 32'h78);
      chk("R6 remaining match", start_slot, 1);
      // flush while a request waits
      @(posedge clk); #2;
      flush_all = 1; req_valid = 1; req_op = 2'd0; req_doorbell = 16'h0011;
      @(posedge clk); #2;
      flush_all = 0; req_valid = 0;
      chk("R9 not accepted", rsp_done, 0);
      chk("R9 all free", slot_busy, 2'b00);
      // back-to-back and random traffic
      for (int n = 0; n < 400; n++) begin
         @(posedge clk); #2;
         flush_all = ($urandom_range(0, 19) == 0);
         req_valid = ($urandom_range(0, 3) != 0);
         req_op = 2'($urandom_range(0, 3));
         req_doorbell = DW'($urandom_range(1, 4));
         req_ring_base = {16'h0, $urandom()};
         req_ring_size = SW'($urandom());
         req_wb_addr = {16'h0, $urandom()};
         req_wptr = $urandom();
      end
      @(posedge clk); #2;
      flush_all = 0; req_valid = 0;
      repeat (2) @(posedge clk);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule